// File: doc/BRIEF.md
# SCSI Controller DMA Transfer Counter

This block holds the byte count of a DMA transfer inside a SCSI protocol controller. Firmware programs a 24-bit start count one byte at a time through three register addresses. Writing a command that has its DMA bit set copies that start count into a separate working counter. The working counter is what firmware sees when it reads the same three addresses. The DMA engine pulses a decrement strobe once for each byte it moves. When the working count runs out, a terminal-count flag is raised.

A start count of zero does not mean "no transfer". It loads 0x010000, which is 64 KiB. The terminal-count flag stays set until one of three register-side events clears it:
- a transfer-information command,
- a read of the interrupt register,
- a write to the FIFO data register.

Bus phases, the FIFO itself and the DMA engine are outside this block. Only the strobe and the count-is-zero output connect it to them. The reset input is expected to arrive already synchronised to the clock.

Top module: `xc_xfer_counter`

## Requirements
- R1: While reset is asserted and after it is released, the start count, the working count and the terminal-count flag are all zero, so reads of addresses 0, 1 and 2 and the status address return 0.
- R2: A write to address 0, 1 or 2 updates only bits [7:0], [15:8] or [23:16] of the start count. Reads of addresses 0, 1 and 2 return the same byte slices of the working count, so a start-count write never changes what those addresses read.
- R3: A write to the command address 4 with bit 7 set loads the working count from the start count on the next clock edge. A command write with bit 7 clear leaves the working count unchanged.
- R4: Loading a start count of zero puts 0x010000 into the working count.
- R5: Each cycle with the decrement strobe high lowers a non-zero working count by exactly one. When the working count is already zero, the strobe is ignored and the counter never wraps.
- R6: When a load and a decrement strobe fall in the same cycle, the load wins and the strobe is dropped.
- R7: The terminal-count flag sets on the edge where a decrement takes the working count from 1 to 0. It is visible on the flag output and as bit 4 of a read of status address 5. A load on its own never sets it, and the flag otherwise holds its value.
- R8: Three events clear the terminal-count flag:
  - a command write whose bits [6:0] equal 0x10 (transfer information), whatever the DMA bit;
  - a read of interrupt address 6;
  - a write to FIFO address 3.

  None of these events changes either count.
- R9: When a decrement that reaches zero and a clearing event fall in the same cycle, the flag ends up set.
- R10: The count-is-zero output is high exactly when the working count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only the interrupt read has a side effect) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address (combinational) |
| dec_stb | input | 1 | One byte moved: decrement the working count |
| count_zero | output | 1 | Working count is zero |
| tc_flag | output | 1 | Terminal-count flag |

## Verification
Two pairs of functions can land on the same edge:
- A DMA-flagged command write can arrive in the cycle where the DMA engine strobes a decrement.
- The final decrement that empties the counter can coincide with a FIFO write, an interrupt read or a transfer-information command.

The bench forces both pairs deliberately in directed steps. It then mixes every operation at random on every cycle. A behavioural model applies the stated priorities: load over decrement, and set over clear. The data read at the driven address, the zero output and the flag are compared against the model before every edge.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int ADDR_W = 3;

  // Register address map
  localparam logic [ADDR_W-1:0] A_FIFO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_INTR = 3'd6;

  // Command encoding
  localparam int            CMD_DMA_BIT = 7;
  localparam logic [6:0]    CMD_XFER    = 7'h10;

  // Status byte layout
  localparam int            STAT_TC_BIT = 4;

  typedef struct packed {
    logic load;
    logic dec;
    logic clr;
  } xc_evt_t;
endpackage

// File: rtl/xc_start_reg.sv
module xc_start_reg #(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8,
  localparam int NBYTES = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] wr_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  start
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic [BYTE_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (wr_sel[i]) byte_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else if (wr_sel[i]) byte_q <= byte_d;
    end

    assign start[i*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/xc_down_counter.sv
module xc_down_counter #(
  parameter int                CNT_W     = 24,
  parameter logic [CNT_W-1:0]  ZERO_LOAD = 24'h010000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] start,
  output logic [CNT_W-1:0] cnt,
  output logic             is_zero,
  output logic             hit_zero
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             dec_ok;

  assign is_zero  = (cnt == '0);
  assign dec_ok   = dec && !load && !is_zero;
  assign hit_zero = dec_ok && (cnt == CNT_W'(1));
  assign cnt_en   = load || dec_ok;

  always_comb begin
    cnt_d = cnt;
    if (load) begin
      cnt_d = (start == '0) ? ZERO_LOAD : start;
    end else if (dec_ok) begin
      cnt_d = cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/xc_tc_flag.sv
module xc_tc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;
  logic flag_en;

  assign flag_en = set || clr;

  always_comb begin
    flag_d = flag;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/xc_xfer_counter.sv
module xc_xfer_counter
  import xc_pkg::*;
#(
  parameter int               CNT_W     = 24,
  parameter int               BYTE_W    = 8,
  parameter logic [CNT_W-1:0] ZERO_LOAD = 24'h010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              dec_stb,
  output logic              count_zero,
  output logic              tc_flag
);
  localparam int NBYTES = CNT_W / BYTE_W;

  xc_evt_t           evt;
  logic [NBYTES-1:0] cnt_sel;
  logic [CNT_W-1:0]  start_cnt;
  logic [CNT_W-1:0]  cur_cnt;
  logic              tc_set;
  logic              cmd_wr;

  // Decode of register side effects
  assign cmd_wr   = reg_wr && (reg_addr == A_CMD);
  assign evt.load = cmd_wr && reg_wdata[CMD_DMA_BIT];
  assign evt.dec  = dec_stb;
  assign evt.clr  = (cmd_wr && (reg_wdata[6:0] == CMD_XFER))
                 || (reg_rd && (reg_addr == A_INTR))
                 || (reg_wr && (reg_addr == A_FIFO));

  for (genvar i = 0; i < NBYTES; i++) begin : g_sel
    assign cnt_sel[i] = reg_wr && (reg_addr == ADDR_W'(i));
  end

  xc_start_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_start (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_sel(cnt_sel),
    .wdata (reg_wdata),
    .start (start_cnt)
  );

  xc_down_counter #(.CNT_W(CNT_W), .ZERO_LOAD(ZERO_LOAD)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (evt.load),
    .dec     (evt.dec),
    .start   (start_cnt),
    .cnt     (cur_cnt),
    .is_zero (count_zero),
    .hit_zero(tc_set)
  );

  xc_tc_flag u_tc (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (tc_set),
    .clr  (evt.clr),
    .flag (tc_flag)
  );

  // Read mux: count bytes, then status
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = cur_cnt[i*BYTE_W +: BYTE_W];
    end
    if (reg_addr == A_STAT) reg_rdata[STAT_TC_BIT] = tc_flag;
  end
endmodule

// File: rtl/xc_xfer_counter_chk.sv
module xc_xfer_counter_chk #(
  parameter int               CNT_W     = 24,
  parameter logic [CNT_W-1:0] ZERO_LOAD = 24'h010000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             dec,
  input logic             clr,
  input logic [CNT_W-1:0] start,
  input logic [CNT_W-1:0] cnt,
  input logic             tc
);
  logic last_dec;
  assign last_dec = dec && !load && (cnt == CNT_W'(1));

  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == (($past(start) == '0) ? ZERO_LOAD : $past(start)));

  assert_load_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && start == '0) |=> cnt == ZERO_LOAD);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(cnt));

  assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && cnt == '0) |=> cnt == '0);

  assert_tc_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_dec |=> tc);

  assert_tc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !last_dec) |=> !tc);

  assert_tc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !last_dec) |=> $stable(tc));
endmodule

bind xc_xfer_counter xc_xfer_counter_chk #(.CNT_W(CNT_W), .ZERO_LOAD(ZERO_LOAD)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .load (evt.load),
  .dec  (evt.dec),
  .clr  (evt.clr),
  .start(start_cnt),
  .cnt  (cur_cnt),
  .tc   (tc_flag)
);

// File: tb/xc_xfer_counter_tb.sv
module xc_xfer_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic       reg_rd;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       dec_stb;
  logic       count_zero;
  logic       tc_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model state
  int unsigned m_start;
  int unsigned m_cur;
  bit          m_tc;

  xc_xfer_counter u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dec_stb   (dec_stb),
    .count_zero(count_zero),
    .tc_flag   (tc_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Model update from the inputs held across the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_cur = 0; m_tc = 0;
    end else begin
      bit ld, clr, st;
      ld  = reg_wr && reg_addr == 3'd4 && reg_wdata[7];
      clr = (reg_wr && reg_addr == 3'd4 && reg_wdata[6:0] == 7'h10)
         || (reg_rd && reg_addr == 3'd6)
         || (reg_wr && reg_addr == 3'd3);
      st  = dec_stb && !ld && m_cur == 1;
      if (ld) m_cur = (m_start == 0) ? 32'h10000 : m_start;
      else if (dec_stb && m_cur != 0) m_cur = m_cur - 1;
      if (st) m_tc = 1;
      else if (clr) m_tc = 0;
      if (reg_wr && reg_addr < 3)
        m_start = (m_start & ~(32'hFF << (8*reg_addr))) | (32'(reg_wdata) << (8*reg_addr));
    end
  end

  function automatic logic [7:0] exp_rdata(input logic [2:0] a);
    case (a)
      3'd0: return m_cur[7:0];
      3'd1: return m_cur[15:8];
      3'd2: return m_cur[23:16];
      3'd5: return {3'b000, m_tc, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before the next rising edge
  task automatic step(input bit wr, input bit rd, input logic [2:0] a,
                      input logic [7:0] d, input bit dc, input string tag);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; dec_stb = dc;
    #1;
    check(tag, "rdata", int'(reg_rdata), int'(exp_rdata(a)));
    check(tag, "count_zero R10", int'(count_zero), int'(m_cur == 0));
    check(tag, "tc_flag", int'(tc_flag), int'(m_tc));
  endtask

  task automatic rd_cnt(input string tag);
    for (int b = 0; b < 3; b++) step(0, 0, 3'(b), 8'h00, 0, tag);
  endtask

  task automatic wr_start(input int unsigned v, input string tag);
    for (int b = 0; b < 3; b++) step(1, 0, 3'(b), 8'(v >> (8*b)), 0, tag);
  endtask

  initial begin
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; dec_stb = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "tc in reset", int'(tc_flag), 0);
    check("R1", "zero in reset", int'(count_zero), 1);
    @(negedge clk); rst_n = 1;
    rd_cnt("R1");
    step(0, 0, 3'd5, 8'h00, 0, "R1");

    wr_start(32'h000003, "R2");
    rd_cnt("R2");
    step(1, 0, 3'd4, 8'h00, 0, "R3");
    rd_cnt("R3");
    step(1, 0, 3'd4, 8'h80, 0, "R3");
    rd_cnt("R3");
    step(0, 0, 3'd0, 8'h00, 1, "R5");
    step(0, 0, 3'd0, 8'h00, 1, "R5");
    step(0, 0, 3'd5, 8'h00, 1, "R7");
    step(0, 0, 3'd5, 8'h00, 1, "R5");
    step(0, 0, 3'd5, 8'h00, 0, "R7");
    check("R7", "tc after 1->0", int'(tc_flag), 1);
    step(0, 1, 3'd6, 8'h00, 0, "R8");
    step(0, 0, 3'd5, 8'h00, 0, "R8");
    check("R8", "tc after intr read", int'(tc_flag), 0);

    wr_start(32'h0, "R4");
    step(1, 0, 3'd4, 8'h80, 0, "R4");
    rd_cnt("R4");
    check("R4", "high byte", int'(reg_rdata), 8'h01);
    step(0, 0, 3'd1, 8'h00, 1, "R5");
    rd_cnt("R5");

    wr_start(32'h000002, "R6");
    step(1, 0, 3'd4, 8'h80, 1, "R6");
    rd_cnt("R6");
    check("R6", "load wins", int'(reg_rdata), 8'h00);

    step(0, 0, 3'd0, 8'h00, 1, "R5");
    step(1, 0, 3'd3, 8'h5A, 1, "R9");
    step(0, 0, 3'd5, 8'h00, 0, "R9");
    check("R9", "set beats clear", int'(tc_flag), 1);
    step(1, 0, 3'd3, 8'h11, 0, "R8");
    step(0, 0, 3'd0, 8'h00, 0, "R8");
    check("R8", "fifo write clears", int'(tc_flag), 0);

    wr_start(32'h000001, "R7");
    step(1, 0, 3'd4, 8'h80, 0, "R7");
    step(0, 0, 3'd5, 8'h00, 0, "R7");
    check("R7", "load alone no tc", int'(tc_flag), 0);
    step(0, 0, 3'd5, 8'h00, 1, "R7");
    step(1, 0, 3'd4, 8'h10, 0, "R8");
    step(0, 0, 3'd5, 8'h00, 0, "R8");
    check("R8", "xfer cmd clears", int'(tc_flag), 0);
    step(1, 0, 3'd4, 8'h90, 0, "R8");
    rd_cnt("R8");

    for (int n = 0; n < 2000; n++) begin
      int unsigned r;
      logic [2:0] a;
      logic [7:0] d;
      r = $urandom;
      a = 3'(r % 7);
      d = 8'(r >> 8);
      if (a < 3) d = (r[20]) ? 8'h00 : {6'b0, d[1:0]};
      if (a == 3'd4) d = {d[7], (r[21] ? 7'h10 : 7'h01)};
      step(r[16], r[17] && !r[16], a, d, r[18] | r[19], "R5");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule